// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Controller

This block holds the register-side status and interrupt logic of one 16550-style UART channel whose receive and transmit FIFOs are each `DEPTH` entries deep. The FIFO storage, the serial shifters and baud generation live outside the block. The block receives the following from outside:

- the occupancy counts of both FIFOs;
- the transmit shifter's idle flag;
- one event per received byte, with that byte's error flags;
- receive-FIFO pop events;
- CPU strobes for writes to the interrupt enable, FIFO control and transmit holding registers;
- CPU strobes for reads of the line status and interrupt identification registers.

From these it produces the line status byte, the interrupt identification byte and one interrupt line.

The receive interrupt follows the programmed FIFO threshold as a level. It rises when occupancy reaches the threshold and falls as soon as occupancy drops below it. The block keeps a shadow record of which queued receive bytes carry errors, so the status register can report whether a bad byte is still waiting in the FIFO. When all enable bits are clear, software polls the status byte and the interrupt line never rises.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, with both counts at zero and the shifter idle, `lsr` is 8'h60, `iir` is 8'h01 and `irq` is 0.
- R2: The receive threshold comes from control bits [7:6]: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. The threshold is these values only while control bit 0 (FIFO enable) is 1; with bit 0 at 0 the threshold is 1.
- R3: While enable bit 0 is set, the receive-data source is pending exactly when `rx_count` is at or above the threshold, in the same cycle as the count changes. Its identification code is 4'h4.
- R4: `lsr[0]` is 1 exactly when `rx_count` is nonzero.
- R5: The cycle after the event, `lsr[1]` (overrun), `lsr[2]` (parity), `lsr[3]` (framing) or `lsr[4]` (break) is set. These come from `rx_overrun` and from `rx_push_err[0]`, `[1]` and `[2]` on a push. A status read clears them, but an error arriving in the same cycle as the read is kept.
- R6: `lsr[5]` is 1 exactly when `tx_count` is zero. `lsr[6]` is 1 exactly when `tx_count` is zero and `tx_idle` is 1.
- R7: `lsr[7]` sets the cycle after a byte with any error flag is pushed. A status read clears it only if no errored byte remains in the receive FIFO, where pops remove bytes in push order.
- R8: Enable register bits come from `wdata[3:0]`. Bit 0 enables receive data, bit 1 enables transmit-empty and bit 2 enables line status. With bits [3:0] all zero, `irq` stays 0 and `iir` shows no pending source.
- R9: The transmit-empty source becomes pending when `tx_count` falls to zero, or when enable bit 1 is written from 0 to 1 while `tx_count` is zero. A transmit holding write clears it, and so does an identification read that shows code 4'h2.
- R10: `iir[3:0]` shows the highest enabled pending source: 4'h6 (line status, any of `lsr[4:1]`), then 4'h4, then 4'h2. It shows 4'h1 when no source is pending. `iir[7:6]` equals 2'b11 while FIFO enable is 1.
- R11: `irq` is 1 exactly when `iir[0]` is 0.
- R12: A control write with `wdata[1]` set forgets all queued error records, so `lsr[7]` reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | CW | Receive FIFO occupancy |
| tx_count | input | CW | Transmit FIFO occupancy |
| tx_idle | input | 1 | Transmit shifter holds no data |
| rx_push | input | 1 | A received byte enters the FIFO |
| rx_push_err | input | 3 | Errors of that byte: {break, framing, parity} |
| rx_pop | input | 1 | The head byte leaves the receive FIFO |
| rx_overrun | input | 1 | A received byte was lost |
| ier_we | input | 1 | Interrupt enable register write |
| fcr_we | input | 1 | FIFO control register write |
| thr_we | input | 1 | Transmit holding register write |
| wdata | input | 8 | Write data |
| lsr_re | input | 1 | Line status register read |
| iir_re | input | 1 | Interrupt identification register read |
| lsr | output | 8 | Line status byte |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Results that depend only on the count and idle inputs are due in the same cycle: data ready, the two transmit-empty bits, the receive-data code and the interrupt line. The bench samples these one time step after it changes the inputs. Results that come from strobes or pushes are due one cycle after the edge that captured them. This covers error bits, the FIFO error flag, transmit-empty pending, enable and control writes, and read-clears. The bench drives those strobes on a falling edge, waits for the next rising edge and samples just after it. Threshold crossings are tested upward and downward at every trigger setting, and the four identification codes are checked as higher sources are removed one at a time.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_idle,
  input  logic          rx_push,
  input  logic [2:0]    rx_push_err,
  input  logic          rx_pop,
  input  logic          rx_overrun,
  input  logic          ier_we,
  input  logic          fcr_we,
  input  logic          thr_we,
  input  logic [7:0]    wdata,
  input  logic          lsr_re,
  input  logic          iir_re,
  output logic [7:0]    lsr,
  output logic [7:0]    iir,
  output logic          irq
);

  logic [3:0]    ier;
  logic          fifo_en;
  logic [1:0]    trig_sel;
  logic [CW-1:0] trig;
  logic [DEPTH-1:0] eflag;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] ecnt, ecnt_nxt;
  logic [4:1]    lerr;
  logic          fifo_err, thre_pend, tx_empty_q;
  logic          rls_p, rda_p, thr_p;
  logic [3:0]    code;

  wire tx_empty = (tx_count == '0);
  wire push_bad = rx_push && (|rx_push_err);
  wire pop_bad  = rx_pop && eflag[rp];
  wire rx_rst   = fcr_we && wdata[1];
  wire unused_bits = ^{wdata[5:4], ier[3]};

  always_comb begin
    if (!fifo_en) trig = CW'(TRIG_0);
    else begin
      case (trig_sel)
        2'd0:    trig = CW'(TRIG_0);
        2'd1:    trig = CW'(TRIG_1);
        2'd2:    trig = CW'(TRIG_2);
        default: trig = CW'(TRIG_3);
      endcase
    end
  end

  always_comb begin
    ecnt_nxt = ecnt;
    if (push_bad && !pop_bad) ecnt_nxt = ecnt + 1'b1;
    else if (pop_bad && !push_bad) ecnt_nxt = ecnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier      <= '0;
      fifo_en  <= 1'b0;
      trig_sel <= '0;
    end else begin
      if (ier_we) ier <= wdata[3:0];
      if (fcr_we) begin
        fifo_en  <= wdata[0];
        trig_sel <= wdata[7:6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eflag <= '0;
      wp    <= '0;
      rp    <= '0;
      ecnt  <= '0;
    end else if (rx_rst) begin
      eflag <= '0;
      wp    <= '0;
      rp    <= '0;
      ecnt  <= '0;
    end else begin
      if (rx_push) begin
        eflag[wp] <= push_bad;
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (rx_pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      ecnt <= ecnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lerr     <= '0;
      fifo_err <= 1'b0;
    end else begin
      lerr <= (lsr_re ? 4'b0 : lerr) |
              {rx_push && rx_push_err[2], rx_push && rx_push_err[1],
               rx_push && rx_push_err[0], rx_overrun};
      if (rx_rst)        fifo_err <= 1'b0;
      else if (push_bad) fifo_err <= 1'b1;
      else if (lsr_re)   fifo_err <= (ecnt_nxt != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend  <= 1'b0;
      tx_empty_q <= 1'b1;
    end else begin
      tx_empty_q <= tx_empty;
      if (thr_we)
        thre_pend <= 1'b0;
      else if ((tx_empty && !tx_empty_q) ||
               (ier_we && wdata[1] && !ier[1] && tx_empty))
        thre_pend <= 1'b1;
      else if (iir_re && code == 4'h2)
        thre_pend <= 1'b0;
    end
  end

  assign rls_p = ier[2] && (|lerr);
  assign rda_p = ier[0] && (rx_count >= trig);
  assign thr_p = ier[1] && thre_pend;

  always_comb begin
    if (rls_p)      code = 4'h6;
    else if (rda_p) code = 4'h4;
    else if (thr_p) code = 4'h2;
    else            code = 4'h1;
  end

  assign iir = {{2{fifo_en}}, 2'b00, code};
  assign irq = rls_p | rda_p | thr_p;
  assign lsr = {fifo_err, tx_empty && tx_idle, tx_empty, lerr, rx_count != '0};

endmodule

module uart_irq_status_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          tx_idle,
  input logic          rx_push,
  input logic [2:0]    rx_push_err,
  input logic          rx_overrun,
  input logic          lsr_re,
  input logic [3:0]    ier,
  input logic [6:0]    lsr,
  input logic [3:0]    iir,
  input logic          irq
);

  a_r4_data_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !lsr[0]);

  a_r6_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && tx_idle) |-> (lsr[6] && lsr[5]));

  a_r6_tx_order: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_re && !rx_overrun && !(rx_push && |rx_push_err)) |=> (lsr[4:1] == 4'b0));

  a_r8_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0) |-> (!irq && iir == 4'h1));

  a_r10_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && lsr[4:1] != 4'b0) |-> (iir == 4'h6));

  a_r11_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);

endmodule

bind uart_irq_status uart_irq_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
  .tx_idle(tx_idle), .rx_push(rx_push), .rx_push_err(rx_push_err),
  .rx_overrun(rx_overrun), .lsr_re(lsr_re), .ier(ier), .lsr(lsr[6:0]),
  .iir(iir[3:0]), .irq(irq)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic tx_idle = 1'b1, rx_push = 1'b0, rx_pop = 1'b0, rx_overrun = 1'b0;
  logic [2:0] rx_push_err = '0;
  logic ier_we = 1'b0, fcr_we = 1'b0, thr_we = 1'b0, lsr_re = 1'b0, iir_re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] lsr, iir;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_status u_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .tx_idle(tx_idle), .rx_push(rx_push), .rx_push_err(rx_push_err),
    .rx_pop(rx_pop), .rx_overrun(rx_overrun), .ier_we(ier_we), .fcr_we(fcr_we),
    .thr_we(thr_we), .wdata(wdata), .lsr_re(lsr_re), .iir_re(iir_re),
    .lsr(lsr), .iir(iir), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
    ier_we = 0; fcr_we = 0; thr_we = 0; lsr_re = 0; iir_re = 0;
    rx_push = 0; rx_pop = 0; rx_overrun = 0; rx_push_err = '0;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    @(negedge clk); ier_we = 1; wdata = v; tick();
  endtask
  task automatic wr_fcr(input logic [7:0] v);
    @(negedge clk); fcr_we = 1; wdata = v; tick();
  endtask
  task automatic rd_lsr;
    @(negedge clk); lsr_re = 1; tick();
  endtask
  task automatic rd_iir;
    @(negedge clk); iir_re = 1; tick();
  endtask
  task automatic wr_thr;
    @(negedge clk); thr_we = 1; tick();
  endtask
  task automatic push(input logic [2:0] e);
    @(negedge clk); rx_push = 1; rx_push_err = e; rx_count = rx_count + 1'b1; tick();
  endtask
  task automatic pop;
    @(negedge clk); rx_pop = 1; rx_count = rx_count - 1'b1; tick();
  endtask
  task automatic set_rx(input logic [CW-1:0] c);
    @(negedge clk); rx_count = c; #1;
  endtask

  task automatic t_reset;
    chk("R1 lsr", lsr, 8'h60);
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_trigger;
    int lv[4] = '{1, 4, 8, 14};
    wr_ier(8'h01);
    for (int s = 0; s < 4; s++) begin
      wr_fcr(8'h01 | 8'(s << 6));
      set_rx(CW'(lv[s] - 1));
      chk("R2 below", {7'b0, irq}, 8'h00);
      set_rx(CW'(lv[s]));
      chk("R3 reach irq", {7'b0, irq}, 8'h01);
      chk("R3 reach iir", iir, 8'hC4);
      set_rx(CW'(lv[s] - 1));
      chk("R3 drop iir", iir, 8'hC1);
    end
    wr_fcr(8'hC0);
    set_rx(1);
    chk("R2 fifo off", iir, 8'h04);
    set_rx(0);
    chk("R3 empty", {7'b0, irq}, 8'h00);
    wr_fcr(8'h01);
  endtask

  task automatic t_dready;
    wr_fcr(8'h03);
    set_rx(0);
    chk("R4 empty", {7'b0, lsr[0]}, 8'h00);
    push(3'b000);
    chk("R4 one", {7'b0, lsr[0]}, 8'h01);
    pop();
    chk("R4 popped", {7'b0, lsr[0]}, 8'h00);
  endtask

  task automatic t_errors;
    wr_ier(8'h04); rd_lsr();
    for (int b = 0; b < 3; b++) begin
      push(3'(1 << b));
      chk("R5 bit", {3'b0, lsr[4:1]}, 8'(2 << b));
      chk("R5 iir", iir, 8'hC6);
      rd_lsr();
      chk("R5 cleared", {3'b0, lsr[4:1]}, 8'h00);
      pop();
    end
    @(negedge clk); rx_overrun = 1; tick();
    chk("R5 overrun", {3'b0, lsr[4:1]}, 8'h01);
    @(negedge clk); lsr_re = 1; rx_push = 1; rx_push_err = 3'b001; rx_count = rx_count + 1'b1; tick();
    chk("R5 set wins", {3'b0, lsr[4:1]}, 8'h02);
    rd_lsr(); pop();
    chk("R5 irq off", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_tx;
    @(negedge clk); tx_count = 5; tx_idle = 0; #1;
    chk("R6 busy", {6'b0, lsr[6:5]}, 8'h00);
    @(negedge clk); tx_count = 0; #1;
    chk("R6 fifo empty", {6'b0, lsr[6:5]}, 8'h01);
    @(negedge clk); tx_idle = 1; #1;
    chk("R6 all idle", {6'b0, lsr[6:5]}, 8'h03);
    wr_thr();
  endtask

  task automatic t_fifo_err;
    wr_fcr(8'h03); rd_lsr();
    chk("R7 clean", {7'b0, lsr[7]}, 8'h00);
    push(3'b000); push(3'b010); push(3'b000);
    chk("R7 set", {7'b0, lsr[7]}, 8'h01);
    rd_lsr();
    chk("R7 remains", {7'b0, lsr[7]}, 8'h01);
    pop(); pop();
    chk("R7 sticky", {7'b0, lsr[7]}, 8'h01);
    rd_lsr();
    chk("R7 cleared", {7'b0, lsr[7]}, 8'h00);
    pop();
  endtask

  task automatic t_polled;
    wr_ier(8'h00);
    set_rx(14);
    push(3'b100);
    @(negedge clk); tx_count = 2; tick();
    @(negedge clk); tx_count = 0; tick();
    chk("R8 no irq", {7'b0, irq}, 8'h00);
    chk("R8 iir", iir, 8'hC1);
    chk("R8 lsr", lsr, 8'hF1);
    rd_lsr(); wr_thr();
    wr_fcr(8'h03); set_rx(0);
  endtask

  task automatic t_thre;
    wr_ier(8'h02);
    chk("R9 enable", iir, 8'hC2);
    rd_iir();
    chk("R9 iir read", iir, 8'hC1);
    @(negedge clk); tx_count = 3; tick();
    @(negedge clk); tx_count = 0; tick();
    chk("R9 drain", iir, 8'hC2);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    wr_thr();
    chk("R9 thr write", iir, 8'hC1);
  endtask

  task automatic t_priority;
    wr_ier(8'h00); wr_fcr(8'h01); rd_lsr();
    push(3'b001);
    wr_ier(8'h07);
    chk("R10 line", iir, 8'hC6);
    rd_lsr();
    chk("R10 rx data", iir, 8'hC4);
    set_rx(0);
    chk("R10 tx empty", iir, 8'hC2);
    rd_iir();
    chk("R10 none", iir, 8'hC1);
    chk("R11 idle", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rxreset;
    push(3'b010);
    chk("R12 pre", {7'b0, lsr[7]}, 8'h01);
    wr_fcr(8'h03);
    chk("R12 reset", {7'b0, lsr[7]}, 8'h00);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R1 in reset", iir, 8'h01);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_trigger();
    t_dready();
    t_errors();
    t_tx();
    t_fifo_err();
    t_polled();
    t_thre();
    t_priority();
    t_rxreset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule